// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a TFT LCD panel: horizontal sync, vertical sync, a data-enable strobe, the current pixel and line positions, and one-cycle markers for the start of the visible picture and the start of the vertical front porch. Software-style configuration arrives as packed words on plain input pins. Every length in those words is biased: the active width is counted in groups of 16 pixels, and the horizontal lengths and the sync heights are stored minus one. The two vertical porches are stored as the plain line count.

The block advances one pixel position on each cycle in which `pix_ce` is high. It runs on the system clock and takes the pixel rate as an enable, so it does not divide any clock. Each line is the horizontal sync, then the back porch, then the active pixels, then the front porch. Each frame is the same four phases in lines. The timing words are copied into shadow registers, and these registers reload only at the end of a frame or while the generator is disabled, so a frame is never built from two different configurations. No pin carries a data stream, so the block has no valid/ready handshake. Every output follows the raster, and nothing downstream can stall it.

Top module: `lcd_raster_timing`

## Requirements
- R1: `pix_x` counts 0 to Htot-1 and then returns to 0, where Htot = (h[15:8]+1) + (h[31:24]+1) + 16*(h[7:2]+1) + (h[23:16]+1). It advances only on clocks where `pix_ce` is high.
- R2: `line_y` advances when `pix_x` wraps, and counts 0 to Vtot-1, where Vtot = (v[15:10]+1) + v[31:24] + (v[9:0]+1) + v[23:16].
- R3: The uninverted hsync is high while `pix_x` < h[15:8]+1. The uninverted vsync is high while `line_y` < v[15:10]+1.
- R4: The uninverted data-enable is high only when `pix_x` is in [hs+hbp, hs+hbp+hact) and `line_y` is in [vs+vbp, vs+vbp+vact), using the decoded lengths of R1 and R2.
- R5: Polarity word bit 12 inverts hsync, bit 11 inverts vsync and bit 14 inverts data-enable. Bit 13 appears on `pclk_inv`. All four bits are taken from the shadow copy.
- R6: While ctrl bit 0 is low, `pix_x` and `line_y` are 0, `sof` and `eof` are low, and each of `hsync`, `vsync` and `de` equals its inversion bit.
- R7: A word changed while the generator is enabled has no effect until the frame in progress wraps. From that wrap on, the new value applies.
- R8: `sof` is high for exactly one clock, the first clock on which `line_y` equals vs+vbp with `pix_x` = 0.
- R9: `eof` is high for one clock, the first clock on the line vs+vbp+vact. When v[23:16] = 0, it is instead high on the first clock of line 0 at the frame wrap.
- R10: `panel_pwr` is high exactly when ctrl bits 0 and 11 are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_ce | input | 1 | Pixel-rate enable |
| h_word | input | 32 | Horizontal timing word |
| v_word | input | 32 | Vertical timing word |
| pol_word | input | 32 | Polarity word (bits 11..14 used) |
| ctrl_word | input | 16 | Control word (bit 0 enable, bit 11 power) |
| hsync | output | 1 | Horizontal sync after inversion |
| vsync | output | 1 | Vertical sync after inversion |
| de | output | 1 | Data-enable after inversion |
| pix_x | output | CNT_W | Pixel position within the line |
| line_y | output | CNT_W | Line position within the frame |
| sof | output | 1 | First active line begins |
| eof | output | 1 | Vertical front porch begins |
| panel_pwr | output | 1 | Panel power request |
| pclk_inv | output | 1 | Panel clock edge inversion flag |

## Verification
The hardest case to reach is a change of the timing words in the middle of a running frame. The old configuration must keep its hold on every output until the exact wrap clock, and that clock can only be reached by counting through a whole frame of pixel enables. The bench uses a small raster of 120 to 160 positions per frame. It rewrites all three words while a frame is half done, under both dense and irregular `pix_ce`, and predicts each position as a quotient and remainder of the pixel count. It also runs a configuration with a zero-line front porch, so that `eof` falls on the wrap itself.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // control word bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_PWR = 11;
  // polarity word bit positions
  localparam int POL_VS  = 11;
  localparam int POL_HS  = 12;
  localparam int POL_PCK = 13;
  localparam int POL_DE  = 14;
  // active width is stored in units of this many pixels
  localparam int H_GRP_SHIFT = 4;
endpackage

// File: rtl/lcdt_decode.sv
module lcdt_decode #(
  parameter int W = 12
) (
  input  logic [31:0]  h_word,
  input  logic [31:0]  v_word,
  output logic [W-1:0] h_sync_end,
  output logic [W-1:0] h_act_start,
  output logic [W-1:0] h_act_end,
  output logic [W-1:0] h_total,
  output logic [W-1:0] v_sync_end,
  output logic [W-1:0] v_act_start,
  output logic [W-1:0] v_act_end,
  output logic [W-1:0] v_total,
  output logic [W-1:0] v_eof_line
);
  import lcdt_pkg::*;

  logic [W-1:0] hsw, hbp, hact, hfp;
  logic [W-1:0] vsw, vbp, vact, vfp;
  logic         unused_lo;

  assign unused_lo = ^h_word[1:0];

  // horizontal lengths: all stored minus one, width in pixel groups
  assign hsw  = W'(h_word[15:8])  + W'(1);
  assign hfp  = W'(h_word[23:16]) + W'(1);
  assign hbp  = W'(h_word[31:24]) + W'(1);
  assign hact = (W'(h_word[7:2]) + W'(1)) << H_GRP_SHIFT;

  // vertical: sync and active biased, porches literal
  assign vact = W'(v_word[9:0])   + W'(1);
  assign vsw  = W'(v_word[15:10]) + W'(1);
  assign vfp  = W'(v_word[23:16]);
  assign vbp  = W'(v_word[31:24]);

  assign h_sync_end  = hsw;
  assign h_act_start = hsw + hbp;
  assign h_act_end   = h_act_start + hact;
  assign h_total     = h_act_end + hfp;

  assign v_sync_end  = vsw;
  assign v_act_start = vsw + vbp;
  assign v_act_end   = v_act_start + vact;
  assign v_total     = v_act_end + vfp;

  // with no front porch the porch "begins" at the wrap to line 0
  assign v_eof_line  = (vfp == '0) ? '0 : v_act_end;
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] sync_end,
  input  logic [W-1:0] act_start,
  input  logic [W-1:0] act_end,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         last,
  output logic         in_sync,
  output logic         in_act
);
  assign last    = (cnt == total - W'(1));
  assign nxt     = last ? '0 : cnt + W'(1);
  assign in_sync = (cnt < sync_end);
  assign in_act  = (cnt >= act_start) && (cnt < act_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (step)   cnt <= nxt;
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < total);
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_ce,
  input  logic [31:0]      h_word,
  input  logic [31:0]      v_word,
  input  logic [31:0]      pol_word,
  input  logic [15:0]      ctrl_word,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] line_y,
  output logic             sof,
  output logic             eof,
  output logic             panel_pwr,
  output logic             pclk_inv
);
  import lcdt_pkg::*;

  logic en;
  logic [31:0] h_q, v_q;
  logic hs_inv_q, vs_inv_q, de_inv_q, pc_inv_q;
  logic unused_cfg;

  logic [CNT_W-1:0] h_se, h_as, h_ae, h_tot;
  logic [CNT_W-1:0] v_se, v_as, v_ae, v_tot, v_eof_line;
  logic [CNT_W-1:0] h_cnt, h_nxt, v_cnt, v_nxt;
  logic h_last, v_last, h_in_sync, h_in_act, v_in_sync, v_in_act;
  logic h_step, v_step, wrap_ld, load;
  logic sof_q, eof_q, sof_d, eof_d;
  logic hs_raw, vs_raw, de_raw;

  assign en = ctrl_word[CTL_EN];
  assign unused_cfg = ^{pol_word[31:15], pol_word[10:0],
                        ctrl_word[15:12], ctrl_word[10:1]};

  assign h_step  = en & pix_ce;
  assign v_step  = h_step & h_last;
  assign wrap_ld = v_step & v_last;
  assign load    = !en | wrap_ld;

  // shadow copies: reload only at a frame wrap or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0; v_q <= '0;
      hs_inv_q <= 1'b0; vs_inv_q <= 1'b0; de_inv_q <= 1'b0; pc_inv_q <= 1'b0;
    end else if (load) begin
      h_q <= h_word; v_q <= v_word;
      hs_inv_q <= pol_word[POL_HS];
      vs_inv_q <= pol_word[POL_VS];
      de_inv_q <= pol_word[POL_DE];
      pc_inv_q <= pol_word[POL_PCK];
    end
  end

  lcdt_decode #(.W(CNT_W)) u_dec (
    .h_word(h_q), .v_word(v_q),
    .h_sync_end(h_se), .h_act_start(h_as), .h_act_end(h_ae), .h_total(h_tot),
    .v_sync_end(v_se), .v_act_start(v_as), .v_act_end(v_ae), .v_total(v_tot),
    .v_eof_line(v_eof_line)
  );

  lcdt_axis #(.W(CNT_W)) u_hax (
    .clk(clk), .rst_n(rst_n), .clr(!en), .step(h_step),
    .sync_end(h_se), .act_start(h_as), .act_end(h_ae), .total(h_tot),
    .cnt(h_cnt), .nxt(h_nxt), .last(h_last),
    .in_sync(h_in_sync), .in_act(h_in_act)
  );

  lcdt_axis #(.W(CNT_W)) u_vax (
    .clk(clk), .rst_n(rst_n), .clr(!en), .step(v_step),
    .sync_end(v_se), .act_start(v_as), .act_end(v_ae), .total(v_tot),
    .cnt(v_cnt), .nxt(v_nxt), .last(v_last),
    .in_sync(v_in_sync), .in_act(v_in_act)
  );

  // frame markers, registered so they align with the new line value
  assign sof_d = v_step && (v_nxt == v_as);
  assign eof_d = v_step && (v_nxt == v_eof_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_q <= 1'b0; eof_q <= 1'b0;
    end else begin
      sof_q <= sof_d; eof_q <= eof_d;
    end
  end

  assign hs_raw = en & h_in_sync;
  assign vs_raw = en & v_in_sync;
  assign de_raw = en & h_in_act & v_in_act;

  assign hsync     = hs_raw ^ hs_inv_q;
  assign vsync     = vs_raw ^ vs_inv_q;
  assign de        = de_raw ^ de_inv_q;
  assign pclk_inv  = pc_inv_q;
  assign sof       = en & sof_q;
  assign eof       = en & eof_q;
  assign panel_pwr = en & ctrl_word[CTL_PWR];
  assign pix_x     = h_cnt;
  assign line_y    = v_cnt;

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pix_x == '0 && line_y == '0));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_ld) |=> ($stable(h_q) && $stable(v_q)));

  // R8
  sof_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (line_y == v_as && pix_x == '0));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sof && eof));

  // R4
  de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> (!hs_raw && !vs_raw));
endmodule

// File: tb/lcd_raster_timing_bench.sv
module lcd_raster_timing_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, pix_ce = 1'b0;
  logic [31:0] h_word = '0, v_word = '0, pol_word = '0;
  logic [15:0] ctrl_word = '0;
  logic hsync, vsync, de, sof, eof, panel_pwr, pclk_inv;
  logic [11:0] pix_x, line_y;

  lcd_raster_timing u_lcd_raster_timing (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .h_word(h_word), .v_word(v_word),
    .pol_word(pol_word), .ctrl_word(ctrl_word), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_x(pix_x), .line_y(line_y), .sof(sof), .eof(eof),
    .panel_pwr(panel_pwr), .pclk_inv(pclk_inv)
  );

  int vectors = 0, fails = 0;
  string tag = "RST";
  // model state
  int n = 0;
  logic [31:0] c_h = '0, c_v = '0, c_p = '0;
  logic [31:0] p_h, p_v, p_p;
  logic [15:0] p_ctrl;
  logic p_ce, p_rst;
  logic [7:0] lf = 8'hA5;

  function automatic int fld(logic [31:0] w, int lsb, int nb);
    return int'((w >> lsb) & ((32'd1 << nb) - 1));
  endfunction

  task automatic chk(string sig, string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s: got %0d expected %0d at %0t", req, tag, sig, act, exp, $time);
    end
  endtask

  task automatic cyc(logic ce);
    int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp, htot, vtot, x, y;
    bit e_sof, e_eof, en;
    pix_ce = ce;
    p_h = h_word; p_v = v_word; p_p = pol_word; p_ctrl = ctrl_word;
    p_ce = ce; p_rst = rst_n;
    @(negedge clk);
    e_sof = 0; e_eof = 0;
    en = p_rst && p_ctrl[0];
    hsw = fld(c_h, 8, 8) + 1; hfp = fld(c_h, 16, 8) + 1; hbp = fld(c_h, 24, 8) + 1;
    hact = 16 * (fld(c_h, 2, 6) + 1);
    vact = fld(c_v, 0, 10) + 1; vsw = fld(c_v, 10, 6) + 1;
    vfp = fld(c_v, 16, 8); vbp = fld(c_v, 24, 8);
    htot = hsw + hbp + hact + hfp; vtot = vsw + vbp + vact + vfp;
    if (!p_rst) begin
      n = 0; c_h = '0; c_v = '0; c_p = '0;
    end else if (!p_ctrl[0]) begin
      n = 0; c_h = p_h; c_v = p_v; c_p = p_p;
    end else if (p_ce) begin
      n++;
      if (n == htot * vtot) n = 0;
      if (n % htot == 0) begin
        if (n / htot == vsw + vbp) e_sof = 1;
        if (n / htot == (vsw + vbp + vact) % vtot) e_eof = 1;
      end
      if (n == 0) begin c_h = p_h; c_v = p_v; c_p = p_p; end
    end
    // recompute with the configuration now in the shadow
    hsw = fld(c_h, 8, 8) + 1; hfp = fld(c_h, 16, 8) + 1; hbp = fld(c_h, 24, 8) + 1;
    hact = 16 * (fld(c_h, 2, 6) + 1);
    vact = fld(c_v, 0, 10) + 1; vsw = fld(c_v, 10, 6) + 1;
    vbp = fld(c_v, 24, 8);
    htot = hsw + hbp + hact + hfp;
    x = n % htot; y = n / htot;
    chk("pix_x", en ? "R1" : "R6", int'(pix_x), x);
    chk("line_y", en ? "R2" : "R6", int'(line_y), y);
    chk("hsync", "R3/R5", int'(hsync), int'((en && x < hsw) ^ c_p[12]));
    chk("vsync", "R3/R5", int'(vsync), int'((en && y < vsw) ^ c_p[11]));
    chk("de", "R4/R5", int'(de), int'((en && x >= hsw + hbp && x < hsw + hbp + hact
         && y >= vsw + vbp && y < vsw + vbp + vact) ^ c_p[14]));
    chk("pclk_inv", "R5", int'(pclk_inv), int'(c_p[13]));
    chk("sof", "R8", int'(sof), int'(e_sof));
    chk("eof", "R9", int'(eof), int'(e_eof));
    chk("panel_pwr", "R10", int'(panel_pwr), int'(en && p_ctrl[11]));
  endtask

  task automatic run(int ncyc, int mode);
    for (int i = 0; i < ncyc; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (mode == 0) cyc(1'b1);
      else if (mode == 1) cyc(i % 3 == 0);
      else cyc(lf[0] | lf[2]);
    end
  endtask

  // line 20 positions, frame 6 lines
  localparam logic [31:0] H1 = {8'd1, 8'd0, 8'd0, 6'd0, 2'b00};
  localparam logic [31:0] V1 = {8'd1, 8'd1, 6'd0, 10'd2};
  // line 40 positions, frame 4 lines, no porches vertically
  localparam logic [31:0] H2 = {8'd0, 8'd3, 8'd2, 6'd1, 2'b00};
  localparam logic [31:0] V2 = {8'd0, 8'd0, 6'd1, 10'd1};

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    run(3, 0);                        // reset state
    rst_n = 1'b1;
    tag = "R6";
    h_word = H1; v_word = V1;
    for (int p = 0; p < 16; p++) begin // R5 polarity sweep while idle
      pol_word = {17'd0, p[3:0], 11'd0};
      ctrl_word = {4'd0, p[0], 11'd0};
      run(3, 0);
    end
    pol_word = '0; ctrl_word = 16'h0801;
    tag = "DENSE";
    run(300, 0);
    tag = "SPARSE";
    run(800, 1);
    ctrl_word = 16'h0000; tag = "R6";
    run(10, 0);
    h_word = H2; v_word = V2; pol_word = 32'h0000_7800;
    run(3, 0);
    ctrl_word = 16'h0001; tag = "IRREG";
    run(700, 2);
    tag = "R7";                       // mid-frame change, dense then irregular
    run(70, 0);
    h_word = H1; v_word = V1; pol_word = 32'h0000_1000;
    run(400, 0);
    run(33, 2);
    h_word = H2; v_word = V2; pol_word = 32'h0000_4800;
    run(800, 2);
    ctrl_word = 16'h0800;
    run(5, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule